// File: doc/BRIEF.md
# SDRAM Clock-Enable Suspend and Power-Down Controller

This block sits on the device side of a synchronous DRAM and decides, cycle by cycle, whether the internal clock advances. The clock-enable pin is registered on every rising edge. The registered value gates the internal clock pulse of the cycle that follows. A cycle whose pulse is withheld discards whatever command is on the bus.

The same withheld pulse has three different effects, depending on what the device is doing:

- **Power-down.** With no burst in flight, the block enters a power-down state. Standby power-down is used when all banks are idle, and active power-down when a bank is open.
- **Data suspend.** During a read or write burst, the block freezes the burst progress counter and raises a data-hold signal. The burst then resumes without losing a beat.
- **Self-refresh.** A self-refresh command issued while clock-enable falls parks the block in self-refresh. In that state the raw clock-enable pin is observed without the sample register. On exit, a lockout of a fixed number of clocked cycles admits only no-operation commands.

Top module: `sdr_cke_ctrl`

## Requirements
- R1: In the running state, `iclk_en` during a cycle equals the value of `cke` sampled at the rising edge that opened that cycle. Reset leaves `iclk_en` low, the state `mode` at running (0) and `burst_left` at 0.
- R2: A command presented in a cycle where `iclk_en` is low is not accepted (`cmd_ok` low) and changes no state. A read in a suspended burst cycle does not restart the burst. Command codes are: 0 no-op, 1 activate, 2 precharge, 3 read, 4 write, 5 self-refresh; codes 6 and 7 act as deselect, which is a no-op.
- R3: When `cke` is sampled low in the running state with no burst pending, `mode` becomes standby power-down (1) if `bank_act` is low, or active power-down (2) if `bank_act` is high.
- R4: In either power-down state, every non-no-op command raises `cmd_err` and is dropped, and `mode` is unchanged. `cmd_ok` and `cmd_err` are never both high.
- R5: The edge that samples `cke` high in power-down returns `mode` to running. The command in the cycle after that edge is accepted.
- R6: An accepted read or write loads `burst_left` with BURST_LEN. `beat` is high in each clocked cycle with `burst_left` nonzero, and each beat decrements `burst_left`. `burst_left` holds on every suspended cycle, so exactly BURST_LEN beats occur whatever the `cke` pattern.
- R7: `dq_hold` is high exactly in suspended cycles with a burst pending. A burst is never turned into power-down: `mode` stays running.
- R8: An accepted self-refresh command with `cke` low at the closing edge sets `mode` to self-refresh (3). A self-refresh command with `cke` high raises `cmd_err` and enters nothing.
- R9: In self-refresh, `sref_wake` follows `cke` combinationally, without waiting for an edge. The first edge that sees `cke` high returns `mode` to running and starts the lockout.
- R10: After self-refresh exit, `lock_busy` is high for exactly LOCK_CYC clocked cycles. During those cycles, non-no-op commands raise `cmd_err` and are not accepted. The first command after the lockout is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable pin |
| cmd | input | 3 | Decoded command code |
| bank_act | input | 1 | High when any bank is open |
| iclk_en | output | 1 | Internal clock pulse enable for this cycle |
| cmd_ok | output | 1 | Command accepted this cycle |
| cmd_err | output | 1 | Illegal command flagged and dropped |
| dq_hold | output | 1 | Freeze data path (burst suspended) |
| beat | output | 1 | Burst beat advances this cycle |
| sref_wake | output | 1 | Self-refresh exit seen on raw pin |
| lock_busy | output | 1 | Post-self-refresh lockout in progress |
| mode | output | 2 | 0 running, 1 standby PD, 2 active PD, 3 self-refresh |
| burst_left | output | $clog2(BURST_LEN+1) | Beats remaining in the current burst |

## Verification
Two functions can coincide in one cycle: burst data suspend and command discard. During a burst, the bench lowers `cke` in an irregular pattern and places a read on the bus in every suspended cycle. A correct design freezes `burst_left`, raises `dq_hold`, withholds `cmd_ok` and keeps `mode` at running. A faulty design either restarts the burst or drops into power-down. The bench judges the outcome with an independent beat model that it updates each cycle, and by checking that the final beat count equals the burst length.

// File: rtl/sdr_cke_ctrl.sv
module sdr_cke_ctrl #(
  parameter int BURST_LEN = 4,
  parameter int LOCK_CYC  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic [2:0] cmd,
  input  logic bank_act,
  output logic iclk_en,
  output logic cmd_ok,
  output logic cmd_err,
  output logic dq_hold,
  output logic beat,
  output logic sref_wake,
  output logic lock_busy,
  output logic [1:0] mode,
  output logic [$clog2(BURST_LEN+1)-1:0] burst_left
);
  localparam int BW = $clog2(BURST_LEN+1);
  localparam int LW = $clog2(LOCK_CYC+1);
  localparam logic [1:0] M_RUN = 2'd0, M_SPD = 2'd1, M_APD = 2'd2, M_SREF = 2'd3;
  localparam logic [2:0] C_READ = 3'd3, C_WRITE = 3'd4, C_SREF = 3'd5;

  logic          cke_q;
  logic [1:0]    mode_q;
  logic [BW-1:0] rem;
  logic [LW-1:0] lock_cnt;

  wire is_nop   = (cmd == 3'd0) || (cmd > 3'd5);
  wire clk_on   = cke_q && (mode_q == M_RUN);
  wire pd       = (mode_q == M_SPD) || (mode_q == M_APD);
  wire locked   = (lock_cnt != '0);
  wire busy     = (rem != '0);
  wire sref_bad = (cmd == C_SREF) && cke;
  wire take     = clk_on && !is_nop && !locked && !sref_bad;
  wire rw       = (cmd == C_READ) || (cmd == C_WRITE);

  assign iclk_en    = clk_on;
  assign cmd_ok     = take;
  assign cmd_err    = !is_nop && (pd || (clk_on && (locked || sref_bad)));
  assign beat       = clk_on && busy;
  assign dq_hold    = !clk_on && busy && (mode_q == M_RUN);
  assign sref_wake  = (mode_q == M_SREF) && cke;
  assign lock_busy  = locked;
  assign mode       = mode_q;
  assign burst_left = rem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q    <= 1'b0;
      mode_q   <= M_RUN;
      rem      <= '0;
      lock_cnt <= '0;
    end else begin
      cke_q <= cke;
      if (take && rw)
        rem <= BW'(BURST_LEN);
      else if (beat)
        rem <= rem - 1'b1;
      if (clk_on && locked)
        lock_cnt <= lock_cnt - 1'b1;
      unique case (mode_q)
        M_RUN: begin
          if (take && (cmd == C_SREF))
            mode_q <= M_SREF;
          else if (!cke && !busy && !locked && !(take && rw))
            mode_q <= bank_act ? M_APD : M_SPD;
        end
        M_SPD, M_APD: if (cke) mode_q <= M_RUN;
        M_SREF: begin
          if (cke) begin
            mode_q   <= M_RUN;
            lock_cnt <= LW'(LOCK_CYC);
          end
        end
        default: mode_q <= M_RUN;
      endcase
    end
  end
endmodule

// File: rtl/sdr_cke_ctrl_chk.sv
module sdr_cke_ctrl_chk #(
  parameter int BURST_LEN = 4,
  parameter int LOCK_CYC  = 6
) (
  input logic clk,
  input logic rst_n,
  input logic cke,
  input logic [2:0] cmd,
  input logic bank_act,
  input logic iclk_en,
  input logic cmd_ok,
  input logic cmd_err,
  input logic dq_hold,
  input logic beat,
  input logic sref_wake,
  input logic lock_busy,
  input logic [1:0] mode,
  input logic [$clog2(BURST_LEN+1)-1:0] burst_left
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  // R1
  iclk_follows_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mode == 2'd0) |-> (iclk_en == $past(cke)));

  // R6
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iclk_en |=> (burst_left == $past(burst_left)));

  // R4
  pd_no_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 || mode == 2'd2) |-> (!iclk_en && !cmd_ok));

  // R4
  ok_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ok && cmd_err));

  // R7
  dq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_hold |-> (burst_left != '0 && !iclk_en && mode == 2'd0));

  // R10
  lock_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_busy && iclk_en && cmd != 3'd0 && cmd < 3'd6) |-> cmd_err);

  // R9
  sref_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !cke) |=> (mode == 2'd3));
endmodule

bind sdr_cke_ctrl sdr_cke_ctrl_chk #(.BURST_LEN(BURST_LEN), .LOCK_CYC(LOCK_CYC)) u_chk (.*);

// File: tb/sdr_cke_ctrl_tb.sv
module sdr_cke_ctrl_tb;
  localparam int BL = 4;
  localparam int LC = 6;
  localparam int BW = $clog2(BL+1);

  logic clk = 0, rst_n = 0, cke = 0, bank_act = 0;
  logic [2:0] cmd = 0;
  logic iclk_en, cmd_ok, cmd_err, dq_hold, beat, sref_wake, lock_busy;
  logic [1:0] mode;
  logic [BW-1:0] burst_left;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  sdr_cke_ctrl #(.BURST_LEN(BL), .LOCK_CYC(LC)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go(input logic k, input logic [2:0] c);
    @(negedge clk);
    cke = k;
    cmd = c;
    #1;
  endtask

  task automatic t_reset;
    chk(mode == 0, "R1 reset mode", mode, 0);
    chk(burst_left == 0, "R1 reset burst", burst_left, 0);
    chk(iclk_en == 0, "R1 reset iclk", iclk_en, 0);
    go(1, 0);
    go(1, 0);
    chk(iclk_en == 1, "R1 clock on", iclk_en, 1);
  endtask

  task automatic t_pd(input logic bact, input int exp);
    bank_act = bact;
    go(1, 0);
    go(0, 0);
    chk(iclk_en == 1, "R1 clocked before suspend", iclk_en, 1);
    go(0, 1);
    chk(mode == exp, "R3 power-down kind", mode, exp);
    chk(iclk_en == 0, "R1 suspended", iclk_en, 0);
    chk(cmd_err == 1 && cmd_ok == 0, "R4 act in pd flagged", cmd_err, 1);
    go(0, 2);
    chk(mode == exp, "R4 mode unchanged", mode, exp);
    go(1, 0);
    chk(mode == exp, "R5 still pd until edge", mode, exp);
    go(1, 1);
    chk(mode == 0, "R5 exit to run", mode, 0);
    chk(cmd_ok == 1, "R5 first command accepted", cmd_ok, 1);
    go(1, 2);
    bank_act = 0;
    go(1, 0);
  endtask

  task automatic t_burst(input logic [2:0] rwc, input logic [15:0] pat);
    int beats = 0;
    int exp_rem = BL;
    logic prev = 1;
    bank_act = 1;
    go(1, rwc);
    chk(cmd_ok == 1, "R6 burst command accepted", cmd_ok, 1);
    for (int i = 0; i < 40; i++) begin
      logic susp = !prev;
      go(pat[i % 16], (susp && exp_rem != 0) ? 3'd3 : 3'd0);
      chk(int'(burst_left) == exp_rem, "R6 burst_left model", burst_left, exp_rem);
      chk(iclk_en == prev, "R1 iclk follows cke", iclk_en, prev);
      if (susp && exp_rem != 0) begin
        chk(dq_hold == 1 && mode == 0, "R7 hold without pd", dq_hold, 1);
        chk(cmd_ok == 0, "R2 read in suspended cycle dropped", cmd_ok, 0);
      end else begin
        chk(dq_hold == 0, "R7 no hold", dq_hold, 0);
      end
      if (beat) beats++;
      if (prev && exp_rem != 0) exp_rem--;
      prev = pat[i % 16];
      if (exp_rem == 0 && burst_left == 0 && i > 0) break;
    end
    chk(beats == BL, "R6 beats preserved", beats, BL);
    go(1, 0);
    go(1, 0);
    chk(mode == 0 && iclk_en == 1, "R5 back to running", mode, 0);
    bank_act = 0;
  endtask

  task automatic t_sref;
    int n = 0;
    go(1, 0);
    go(1, 5);
    chk(cmd_err == 1 && cmd_ok == 0, "R8 sref with cke high flagged", cmd_err, 1);
    go(1, 0);
    chk(mode == 0, "R8 no entry", mode, 0);
    go(0, 5);
    chk(cmd_ok == 1, "R8 sref accepted", cmd_ok, 1);
    go(0, 0);
    chk(mode == 3 && iclk_en == 0, "R8 in self-refresh", mode, 3);
    go(0, 1);
    chk(mode == 3 && sref_wake == 0, "R9 stays asleep", mode, 3);
    @(posedge clk);
    #3;
    cke = 1;
    cmd = 0;
    #1;
    chk(sref_wake == 1, "R9 wake seen without edge", sref_wake, 1);
    chk(mode == 3, "R9 mode before edge", mode, 3);
    go(1, 0);
    for (int i = 0; i < 20; i++) begin
      go(1, 1);
      if (lock_busy) begin
        chk(mode == 0, "R9 running after exit", mode, 0);
        chk(cmd_err == 1 && cmd_ok == 0, "R10 lockout rejects act", cmd_err, 1);
        n++;
      end else begin
        chk(cmd_ok == 1, "R10 accepted after lockout", cmd_ok, 1);
        break;
      end
    end
    chk(n == LC, "R10 lockout length", n, LC);
    go(1, 2);
    go(1, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        t_reset();
        t_pd(0, 1);
        t_pd(1, 2);
        t_burst(3'd3, 16'b1011_0010_1100_1010);
        t_burst(3'd4, 16'b0100_1101_0011_0110);
        t_burst(3'd3, 16'b1111_1111_1111_1111);
        t_sref();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule